// File: doc/BRIEF.md
# Secondary Interrupt Aggregation Controller

The block gathers a parameterised set of level-sensitive interrupt lines (32 by default) and presents them to a primary interrupt controller in two ways. A single combined request goes high while any enabled source is pending. A second output forwards a fixed contiguous window of sources (21 to 30 by default) bit-for-bit onto the primary inputs that have the same numbers. Each bit in that window is forwarded only if its own pass-through bit is set.

Software controls the block over a simple 32-bit register bus: an address, a write enable, write data and combinational read data. Three state vectors are held. These are the enable mask, the software-raised interrupts and the pass-through mask. Each vector is changed through a pair of write-one-to-set and write-one-to-clear registers. Edge capture, priority and vectoring are left to the primary controller.

Top module: `irq_agg`

## Requirements
- R1: After rst_ni is released, the enable mask, software interrupt vector and pass-through mask read as 0, and both irq_o and bypass_o are 0.
- R2: A write to offset 0x08 sets every enable bit where wdata_i is 1. A write to 0x0C clears every enable bit where wdata_i is 1. Zero bits keep their value. The enable mask reads back at 0x08.
- R3: A write to 0x10 sets software interrupt bits where wdata_i is 1. A write to 0x14 clears them where wdata_i is 1. The vector reads back at 0x10.
- R4: A read of 0x04 returns the raw status, which is src_i OR the software interrupt vector.
- R5: A read of 0x00 returns the raw status AND the enable mask.
- R6: irq_o is 1 exactly when the masked status is nonzero.
- R7: A write to 0x20 sets pass-through bits where wdata_i is 1. A write to 0x24 clears them. Only bits 21 to 30 (mask 0x7FE00000) can be stored, and the mask reads back at 0x20.
- R8: bypass_o[n] equals raw status bit n AND pass-through bit n for n in 21..30, and is 0 for every other n.
- R9: Reads of any offset other than 0x00, 0x04, 0x08, 0x10 and 0x20 return 0. Writes to offsets other than the six write offsets leave all state unchanged.
- R10: A register write takes effect at the clock edge where we_i is sampled. irq_o, bypass_o and rdata_o follow src_i and the stored state without any register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Combined masked request |
| bypass_o | output | 32 | Per-source pass-through requests |

## Verification
Software clearing and hardware assertion of the same interrupt bit can fall in one cycle. The raw status must then stay high, because the hardware line still holds it. The bench provokes this by driving a source line high, enabling it and setting its software bit. It then writes a clear of that software bit while the line remains high. It judges the outcome on the raw status read, on irq_o, and on the software vector read. Only when the line later drops do the raw status and irq_o fall.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_MASKED = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_EN_SET = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SW_SET = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_SW_CLR = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PT_SET = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_PT_CLR = 8'h24;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
    logic pt_set;
    logic pt_clr;
  } wr_strb_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MASKED,
    RD_RAW,
    RD_EN,
    RD_SW,
    RD_PT
  } rd_sel_t;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output wr_strb_t          wr_strb_o,
  output rd_sel_t           rd_sel_o
);
  always_comb begin
    wr_strb_o = '0;
    if (we_i) begin
      unique case (addr_i)
        OFF_EN_SET: wr_strb_o.en_set = 1'b1;
        OFF_EN_CLR: wr_strb_o.en_clr = 1'b1;
        OFF_SW_SET: wr_strb_o.sw_set = 1'b1;
        OFF_SW_CLR: wr_strb_o.sw_clr = 1'b1;
        OFF_PT_SET: wr_strb_o.pt_set = 1'b1;
        OFF_PT_CLR: wr_strb_o.pt_clr = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_MASKED: rd_sel_o = RD_MASKED;
      OFF_RAW:    rd_sel_o = RD_RAW;
      OFF_EN_SET: rd_sel_o = RD_EN;
      OFF_SW_SET: rd_sel_o = RD_SW;
      OFF_PT_SET: rd_sel_o = RD_PT;
      default:    rd_sel_o = RD_NONE;
    endcase
  end
endmodule

// File: rtl/irq_agg_w1_reg.sv
// Write-one-to-set / write-one-to-clear vector; KEEP limits storable bits.
module irq_agg_w1_reg #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0]  KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (set_i) q_d = q_d | wdata_i;
    if (clr_i) q_d = q_d & ~wdata_i;
    q_d = q_d & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/irq_agg_bypass.sv
module irq_agg_bypass #(
  parameter int unsigned N  = 32,
  parameter int unsigned LO = 21,
  parameter int unsigned HI = 30
) (
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] pass_i,
  output logic [N-1:0] byp_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i >= LO && i <= HI) begin : g_win
      assign byp_o[i] = raw_i[i] & pass_i[i];
    end else begin : g_off
      assign byp_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o,
  output logic [N_SRC-1:0]  bypass_o
);
  localparam logic [N_SRC:0]   ONE     = (N_SRC+1)'(1);
  localparam logic [N_SRC:0]   WIN     = (ONE << (PT_HI + 1)) - (ONE << PT_LO);
  localparam logic [N_SRC-1:0] PT_KEEP = WIN[N_SRC-1:0];

  wr_strb_t         strb;
  rd_sel_t          rd_sel;
  logic [N_SRC-1:0] en_q, sw_q, pt_q, raw, masked;

  irq_agg_decode i_decode (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wr_strb_o(strb),
    .rd_sel_o (rd_sel)
  );

  irq_agg_w1_reg #(.W(N_SRC)) i_en (
    .clk_i, .rst_ni, .set_i(strb.en_set), .clr_i(strb.en_clr), .wdata_i, .q_o(en_q)
  );

  irq_agg_w1_reg #(.W(N_SRC)) i_sw (
    .clk_i, .rst_ni, .set_i(strb.sw_set), .clr_i(strb.sw_clr), .wdata_i, .q_o(sw_q)
  );

  irq_agg_w1_reg #(.W(N_SRC), .KEEP(PT_KEEP)) i_pt (
    .clk_i, .rst_ni, .set_i(strb.pt_set), .clr_i(strb.pt_clr), .wdata_i, .q_o(pt_q)
  );

  assign raw    = src_i | sw_q;
  assign masked = raw & en_q;
  assign irq_o  = |masked;

  irq_agg_bypass #(.N(N_SRC), .LO(PT_LO), .HI(PT_HI)) i_bypass (
    .raw_i (raw),
    .pass_i(pt_q),
    .byp_o (bypass_o)
  );

  always_comb begin
    unique case (rd_sel)
      RD_MASKED: rdata_o = masked;
      RD_RAW:    rdata_o = raw;
      RD_EN:     rdata_o = en_q;
      RD_SW:     rdata_o = sw_q;
      RD_PT:     rdata_o = pt_q;
      default:   rdata_o = '0;
    endcase
  end

  a_r2_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_EN_SET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  a_r2_en_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_EN_CLR) |=> ((en_q & $past(wdata_i)) == '0));
  a_r3_sw_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_SW_CLR) |=> ((sw_q & $past(wdata_i)) == '0));
  a_r4_raw_holds_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((src_i & ~raw)) == '0));
  a_r6_irq_needs_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((en_q & (src_i | sw_q)) != '0));
  a_r7_pt_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pt_q & ~PT_KEEP) == '0));
  a_r8_bypass_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bypass_o & ~(src_i | sw_q)) == '0));
  a_r9_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != OFF_EN_SET && addr_i != OFF_EN_CLR) |=> $stable(en_q));
endmodule

// File: tb/test_irq_agg.sv
`timescale 1ns/1ps
module test_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [31:0] bypass;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_agg i_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .bypass_o(bypass)
  );

  localparam int NV = 5;
  localparam logic [31:0] PT_WIN = 32'h7FE0_0000;
  localparam logic [31:0] V_SRC[NV] = '{32'h0000_0001, 32'h0020_0000, 32'h0000_0000,
                                        32'h4000_0000, 32'h1234_5678};
  localparam logic [31:0] V_EN [NV] = '{32'h0000_0001, 32'h0000_0000, 32'h8000_0000,
                                        32'hFFFF_0000, 32'h0F0F_0F0F};
  localparam logic [31:0] V_SW [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h8000_0000,
                                        32'h0000_0100, 32'h8000_0001};
  localparam logic [31:0] V_PT [NV] = '{32'h0000_0000, 32'h0020_0000, 32'hFFFF_FFFF,
                                        32'h4000_0000, 32'h7FE0_0000};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clear_all();
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] raw_e, pt_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h08, d); check("R1 enable", d, 0);
    rd(8'h10, d); check("R1 soft", d, 0);
    rd(8'h20, d); check("R1 pass", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 bypass", bypass, 0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      clear_all();
      src = V_SRC[v];
      wr(8'h08, V_EN[v]);
      wr(8'h10, V_SW[v]);
      wr(8'h20, V_PT[v]);
      raw_e = V_SRC[v] | V_SW[v];
      pt_e  = V_PT[v] & PT_WIN;
      rd(8'h08, d); check("R2 enable readback", d, V_EN[v]);
      rd(8'h10, d); check("R3 soft readback", d, V_SW[v]);
      rd(8'h04, d); check("R4 raw", d, raw_e);
      rd(8'h00, d); check("R5 masked", d, raw_e & V_EN[v]);
      check("R6 irq", {31'b0, irq}, {31'b0, |(raw_e & V_EN[v])});
      rd(8'h20, d); check("R7 pass readback", d, pt_e);
      check("R8 bypass", bypass, raw_e & pt_e);
    end

    // R2 write-one semantics: zero bits untouched
    clear_all();
    src = '0;
    wr(8'h08, 32'h0000_000F);
    wr(8'h0C, 32'h0000_0005);
    rd(8'h08, d); check("R2 partial clear", d, 32'h0000_000A);
    wr(8'h08, 32'h0000_0100);
    rd(8'h08, d); check("R2 accumulate set", d, 32'h0000_010A);

    // R10 write visible right after the sampling edge
    clear_all();
    @(negedge clk);
    addr = 8'h10; wdata = 32'h0000_0002; we = 1'b1;
    #1 check("R10 before edge", rdata, 0);
    @(posedge clk); #1;
    check("R10 after edge", rdata, 32'h0000_0002);
    @(negedge clk); we = 1'b0;

    // Same cycle: software clear while hardware line holds bit 3 (R4 R3 R6)
    clear_all();
    src = 32'h0000_0008;
    wr(8'h08, 32'h0000_0008);
    wr(8'h10, 32'h0000_0008);
    wr(8'h14, 32'h0000_0008);
    rd(8'h10, d); check("R3 soft cleared", d, 0);
    rd(8'h04, d); check("R4 raw held by line", d, 32'h0000_0008);
    check("R6 irq held by line", {31'b0, irq}, 1);
    src = '0;
    #1 check("R6 irq drops with line", {31'b0, irq}, 0);

    // R8 pass-through window edges 20, 21, 30, 31
    clear_all();
    src = 32'hC030_0000;
    wr(8'h20, 32'hFFFF_FFFF);
    check("R8 window edges", bypass, 32'h4020_0000);
    wr(8'h24, 32'h0020_0000);
    check("R8 after pass clear", bypass, 32'h4000_0000);
    check("R6 no enable no irq", {31'b0, irq}, 0);

    // R9 unmapped reads and ignored writes
    wr(8'h08, 32'h0000_00F0);
    wr(8'h10, 32'h0000_0F00);
    rd(8'h18, d); check("R9 read 0x18", d, 0);
    rd(8'h0C, d); check("R9 read 0x0C", d, 0);
    rd(8'h24, d); check("R9 read 0x24", d, 0);
    rd(8'h2C, d); check("R9 read 0x2C", d, 0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R9 enable unchanged", d, 32'h0000_00F0);
    rd(8'h10, d); check("R9 soft unchanged", d, 32'h0000_0F00);
    rd(8'h20, d); check("R9 pass unchanged", d, 32'h7FC0_0000);

    // R1 mid-run reset
    rst_n = 1'b0;
    #1 check("R1 irq in reset", {31'b0, irq}, 0);
    src = '0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'h08, d); check("R1 enable after reset", d, 0);
    rd(8'h20, d); check("R1 pass after reset", d, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule